// File: doc/BRIEF.md
# Multithreaded Decode Stall and Skid Stage

This block sits between instruction fetch and rename in a small multithreaded core. Each cycle it accepts a bundle of up to `WIDTH` opaque tagged instructions, each carrying a thread number. It sorts them into per-thread streams and forwards them to rename in a registered output bundle of the same width. Instructions are never interpreted; only their tag and thread number move through the stage.

Every thread runs its own small state machine. Three stall inputs per thread, from rename, from execute and from commit, are captured into flags at each clock edge. A thread with any flag set forwards nothing. Instead, it appends its arriving instructions to a private skid FIFO, so work already in flight when the stall was seen is not lost. Once the flags clear, the thread drains its skid, oldest entry first, ahead of anything newer. It keeps telling fetch to hold off until the skid is empty.

A per-thread squash discards the thread's skid and its arriving instructions. Output slots are shared among threads in ascending thread-number order. Overflow of a skid is reported through a sticky error output.

Top module: `decode_skid_stage`

## Requirements
- R1: After a synchronous active-low reset, `dec_valid` is 0 and every thread state is idle (code 0). `fetch_block` is 0, `skids_empty` is 1, `any_unblocking` is 0 and `skid_overflow` is 0.
- R2: Fetch slot k is described by `fetch_valid[k]`, `fetch_tid[k*TID_W +: TID_W]` and `fetch_tag[k*TAG_W +: TAG_W]`, and output slot k uses the same layout. An instruction for an unstalled thread with an empty skid appears on the output one clock edge after it is presented. Within a thread, order is preserved. Valid output slots always form a prefix starting at slot 0.
- R3: Each skid holds `DEPTH` entries. When more instructions must be kept, the oldest `DEPTH` are retained and the rest are dropped. `skid_overflow[t]` then rises and stays high until reset.
- R4: Each of `stall_rename[t]`, `stall_exec[t]` and `stall_commit[t]` is sampled into a flag at every clock edge. While any flag of thread t is set, the thread forwards nothing, appends its arriving instructions to its skid, reports state blocked (code 2) and asserts `fetch_block[t]`. Other threads are unaffected.
- R5: When its flags clear, a thread with skid contents forwards the skid entries, oldest first, before any newer instruction. It reports state unblocking (code 3) and keeps `fetch_block[t]` high until its skid is empty, then reports running (code 1).
- R6: `squash[t]` discards thread t's skid contents and its instructions arriving in that cycle and the following cycle. The thread reports state squashing (code 4) for one cycle, then idle. Other threads are unaffected.
- R7: At most `WIDTH` instructions leave per cycle. Lower-numbered threads take output slots first. Instructions of a higher thread that do not fit go into its skid, and that thread becomes unblocking.
- R8: `any_unblocking` is high exactly when some thread is unblocking. `skids_empty` is high exactly when every skid is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | WIDTH | Per-slot valid of the fetch bundle |
| fetch_tid | input | WIDTH*TID_W | Per-slot thread number |
| fetch_tag | input | WIDTH*TAG_W | Per-slot instruction tag |
| stall_rename | input | NT | Per-thread stall request from rename |
| stall_exec | input | NT | Per-thread stall request from execute |
| stall_commit | input | NT | Per-thread stall request from commit |
| squash | input | NT | Per-thread squash |
| dec_valid | output | WIDTH | Per-slot valid of the output bundle |
| dec_tid | output | WIDTH*TID_W | Per-slot thread number of the output |
| dec_tag | output | WIDTH*TAG_W | Per-slot tag of the output |
| thread_state | output | NT*3 | Per-thread state code (0 idle, 1 running, 2 blocked, 3 unblocking, 4 squashing) |
| fetch_block | output | NT | Per-thread hold request to fetch |
| any_unblocking | output | 1 | Some thread is unblocking |
| skids_empty | output | 1 | All skids are empty |
| skid_overflow | output | NT | Sticky per-thread skid overflow error |

## Verification
The bench builds the stage with two threads, a width of two, eight-bit tags and a skid depth of four. Two threads are enough to show a lower thread draining a full-width skid while a higher thread is pushed into its own skid. A depth of four fills in two stalled cycles, so the third stalled bundle reaches overflow. A width of two also lets one bundle mix both threads, so squash isolation and the ordering of output slots by thread number can each be seen in a single cycle.

// File: rtl/decode_skid_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the decode stall/skid stage.
// Assumes nothing beyond a 3-bit state code visible at the top ports.
package decode_skid_pkg;

    typedef enum logic [2:0] {
        TS_IDLE    = 3'd0,
        TS_RUN     = 3'd1,
        TS_BLOCKED = 3'd2,
        TS_UNBLOCK = 3'd3,
        TS_SQUASH  = 3'd4
    } thr_state_e;

endpackage

// File: rtl/decode_fetch_sorter.sv
`timescale 1ns/1ps
// Module: decode_fetch_sorter
// Splits a fetch bundle into one compacted list per thread, keeping the
// slot order within each thread. Purely combinational.
// Assumes thread numbers at or above NT never appear on a valid slot.
module decode_fetch_sorter #(
    parameter  int NT    = 2,
    parameter  int WIDTH = 2,
    parameter  int TID_W = 1,
    parameter  int TAG_W = 8,
    localparam int CW    = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0]                    fetch_valid,
    input  logic [WIDTH*TID_W-1:0]              fetch_tid,
    input  logic [WIDTH*TAG_W-1:0]              fetch_tag,
    output logic [NT-1:0][CW-1:0]               thr_cnt,
    output logic [NT-1:0][WIDTH-1:0][TAG_W-1:0] thr_tags
);

    // Compact each thread's instructions into the low entries of its list.
    always_comb begin
        thr_cnt  = '0;
        thr_tags = '0;
        for (int t = 0; t < NT; t++) begin
            for (int s = 0; s < WIDTH; s++) begin
                if (fetch_valid[s] && (fetch_tid[s*TID_W +: TID_W] == TID_W'(t))) begin
                    thr_tags[t][int'(thr_cnt[t])] = fetch_tag[s*TAG_W +: TAG_W];
                    thr_cnt[t] = thr_cnt[t] + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/decode_thread_lane.sv
`timescale 1ns/1ps
// Module: decode_thread_lane
// One thread's slice of the decode stage: stall flags, state machine and
// skid FIFO. Skid entries are always forwarded ahead of new arrivals.
// Takes up to budget_in output slots and hands the remainder on.
// Assumes DEPTH >= WIDTH and in_cnt <= WIDTH.
module decode_thread_lane
    import decode_skid_pkg::*;
#(
    parameter  int WIDTH = 2,
    parameter  int TAG_W = 8,
    parameter  int DEPTH = 4,
    localparam int CW    = $clog2(WIDTH + 1),
    localparam int SCW   = $clog2(DEPTH + 1),
    localparam int MW    = DEPTH + WIDTH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2:0]                  stall_src,
    input  logic                        squash_in,
    input  logic [CW-1:0]               in_cnt,
    input  logic [WIDTH-1:0][TAG_W-1:0] in_tags,
    input  logic [CW-1:0]               budget_in,
    output logic [CW-1:0]               budget_out,
    output logic [WIDTH-1:0][TAG_W-1:0] emit_tags,
    output logic [2:0]                  state_o,
    output logic                        skid_empty_o,
    output logic                        overflow_o
);

    logic [2:0]                  flags_q;
    thr_state_e                  state_q, state_d;
    logic [DEPTH-1:0][TAG_W-1:0] skid_q, skid_d;
    logic [SCW-1:0]              cnt_q, cnt_d;
    logic                        ovf_q, ovf_hit;
    logic [TAG_W-1:0]            merged [MW];
    logic                        stalled, drop;
    int                          total_n, take_n, keep_n;

    // Build the ordered work list: skid contents first, then new arrivals.
    always_comb begin
        merged = '{default: '0};
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(cnt_q)) merged[i] = skid_q[i];
        end
        for (int j = 0; j < WIDTH; j++) begin
            if (j < int'(in_cnt)) merged[int'(cnt_q) + j] = in_tags[j];
        end
    end

    // Decide how many entries leave, how many are kept, and the next state.
    always_comb begin
        stalled = |flags_q;
        drop    = squash_in || (state_q == TS_SQUASH);
        total_n = int'(cnt_q) + int'(in_cnt);
        take_n  = 0;
        if (!drop && !stalled)
            take_n = (total_n < int'(budget_in)) ? total_n : int'(budget_in);
        keep_n     = drop ? 0 : total_n - take_n;
        ovf_hit    = keep_n > DEPTH;
        cnt_d      = SCW'(ovf_hit ? DEPTH : keep_n);
        budget_out = budget_in - CW'(take_n);
        if (squash_in)         state_d = TS_SQUASH;
        else if (drop)         state_d = stalled ? TS_BLOCKED : TS_IDLE;
        else if (stalled)      state_d = TS_BLOCKED;
        else if (cnt_d != '0)  state_d = TS_UNBLOCK;
        else if (take_n != 0)  state_d = TS_RUN;
        else                   state_d = TS_IDLE;
    end

    // Shift the work list: leaving entries go out, the oldest survivors stay.
    always_comb begin
        for (int j = 0; j < DEPTH; j++)
            skid_d[j] = (j < int'(cnt_d)) ? merged[j + take_n] : '0;
        for (int j = 0; j < WIDTH; j++)
            emit_tags[j] = (j < take_n) ? merged[j] : '0;
    end

    // State, flags, skid storage and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            state_q <= TS_IDLE;
            skid_q  <= '0;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            flags_q <= stall_src;
            state_q <= state_d;
            skid_q  <= skid_d;
            cnt_q   <= cnt_d;
            ovf_q   <= ovf_q | ovf_hit;
        end
    end

    assign state_o      = state_q;
    assign skid_empty_o = (cnt_q == '0);
    assign overflow_o   = ovf_q;

    // A blocked state is only reached through a stall flag seen the cycle before.
    assert_blocked_by_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_BLOCKED) |-> $past(|flags_q));

    // Running or idle threads never hold skid entries.
    assert_drained_before_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == TS_RUN) || (state_q == TS_IDLE)) |-> (cnt_q == '0));

    // A squash empties the skid and enters the squashing state.
    assert_squash_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        squash_in |=> ((cnt_q == '0) && (state_q == TS_SQUASH)));

    // Overflow error stays set once raised.
    assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

endmodule

// File: rtl/decode_out_packer.sv
`timescale 1ns/1ps
// Module: decode_out_packer
// Places each thread's leaving instructions into consecutive output slots,
// lower threads first, using the slot-budget chain, and registers the bundle.
// Assumes budget_chain[0] == WIDTH and the chain never increases.
module decode_out_packer #(
    parameter  int NT    = 2,
    parameter  int WIDTH = 2,
    parameter  int TID_W = 1,
    parameter  int TAG_W = 8,
    localparam int CW    = $clog2(WIDTH + 1)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NT:0][CW-1:0]                 budget_chain,
    input  logic [NT-1:0][WIDTH-1:0][TAG_W-1:0] emit_tags,
    output logic [WIDTH-1:0]                    dec_valid,
    output logic [WIDTH*TID_W-1:0]              dec_tid,
    output logic [WIDTH*TAG_W-1:0]              dec_tag
);

    logic [WIDTH-1:0]       v_d;
    logic [WIDTH*TID_W-1:0] tid_d;
    logic [WIDTH*TAG_W-1:0] tag_d;
    int                     used_n, lo_n, hi_n;

    // Map output slot s to the thread whose slot range covers it.
    always_comb begin
        used_n = WIDTH - int'(budget_chain[NT]);
        tid_d  = '0;
        tag_d  = '0;
        lo_n   = 0;
        hi_n   = 0;
        for (int s = 0; s < WIDTH; s++) begin
            v_d[s] = (s < used_n);
            for (int t = 0; t < NT; t++) begin
                lo_n = WIDTH - int'(budget_chain[t]);
                hi_n = WIDTH - int'(budget_chain[t+1]);
                if ((s >= lo_n) && (s < hi_n)) begin
                    tid_d[s*TID_W +: TID_W] = TID_W'(t);
                    tag_d[s*TAG_W +: TAG_W] = emit_tags[t][s - lo_n];
                end
            end
        end
    end

    // Output bundle register toward rename.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= '0;
            dec_tid   <= '0;
            dec_tag   <= '0;
        end else begin
            dec_valid <= v_d;
            dec_tid   <= tid_d;
            dec_tag   <= tag_d;
        end
    end

    // Valid slots form a prefix starting at slot 0.
    assert_valid_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_valid + WIDTH'(1)) & dec_valid) == '0);

endmodule

// File: rtl/decode_skid_stage.sv
`timescale 1ns/1ps
// Module: decode_skid_stage (top)
// Multithreaded decode stage: sorts the fetch bundle by thread and runs one
// lane per thread, chaining the output-slot budget from thread 0 upward.
// It packs and registers the output bundle and reports per-thread state and
// hold requests. Assumes DEPTH >= WIDTH; all NT threads are active.
module decode_skid_stage
    import decode_skid_pkg::*;
#(
    parameter  int NT    = 2,
    parameter  int WIDTH = 2,
    parameter  int TAG_W = 8,
    parameter  int DEPTH = 4,
    localparam int TID_W = (NT > 1) ? $clog2(NT) : 1,
    localparam int CW    = $clog2(WIDTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WIDTH-1:0]       fetch_valid,
    input  logic [WIDTH*TID_W-1:0] fetch_tid,
    input  logic [WIDTH*TAG_W-1:0] fetch_tag,
    input  logic [NT-1:0]          stall_rename,
    input  logic [NT-1:0]          stall_exec,
    input  logic [NT-1:0]          stall_commit,
    input  logic [NT-1:0]          squash,
    output logic [WIDTH-1:0]       dec_valid,
    output logic [WIDTH*TID_W-1:0] dec_tid,
    output logic [WIDTH*TAG_W-1:0] dec_tag,
    output logic [NT*3-1:0]        thread_state,
    output logic [NT-1:0]          fetch_block,
    output logic                   any_unblocking,
    output logic                   skids_empty,
    output logic [NT-1:0]          skid_overflow
);

    logic [NT-1:0][CW-1:0]               thr_cnt;
    logic [NT-1:0][WIDTH-1:0][TAG_W-1:0] thr_tags;
    logic [NT:0][CW-1:0]                 budget;
    logic [NT-1:0][WIDTH-1:0][TAG_W-1:0] emit_tags;
    logic [NT-1:0][2:0]                  state_w;
    logic [NT-1:0]                       empty_w;

    decode_fetch_sorter #(
        .NT(NT), .WIDTH(WIDTH), .TID_W(TID_W), .TAG_W(TAG_W)
    ) u_sorter (
        .fetch_valid (fetch_valid),
        .fetch_tid   (fetch_tid),
        .fetch_tag   (fetch_tag),
        .thr_cnt     (thr_cnt),
        .thr_tags    (thr_tags)
    );

    assign budget[0] = CW'(WIDTH);

    for (genvar t = 0; t < NT; t++) begin : g_lane
        decode_thread_lane #(
            .WIDTH(WIDTH), .TAG_W(TAG_W), .DEPTH(DEPTH)
        ) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .stall_src    ({stall_commit[t], stall_exec[t], stall_rename[t]}),
            .squash_in    (squash[t]),
            .in_cnt       (thr_cnt[t]),
            .in_tags      (thr_tags[t]),
            .budget_in    (budget[t]),
            .budget_out   (budget[t+1]),
            .emit_tags    (emit_tags[t]),
            .state_o      (state_w[t]),
            .skid_empty_o (empty_w[t]),
            .overflow_o   (skid_overflow[t])
        );

        assign thread_state[t*3 +: 3] = state_w[t];
        assign fetch_block[t] = (state_w[t] == TS_BLOCKED) || (state_w[t] == TS_UNBLOCK);
    end

    decode_out_packer #(
        .NT(NT), .WIDTH(WIDTH), .TID_W(TID_W), .TAG_W(TAG_W)
    ) u_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .budget_chain (budget),
        .emit_tags    (emit_tags),
        .dec_valid    (dec_valid),
        .dec_tid      (dec_tid),
        .dec_tag      (dec_tag)
    );

    // Aggregate status across all threads.
    always_comb begin
        any_unblocking = 1'b0;
        for (int t = 0; t < NT; t++)
            any_unblocking = any_unblocking | (state_w[t] == TS_UNBLOCK);
        skids_empty = &empty_w;
    end

    // An unblocking thread always holds skid entries.
    assert_unblock_has_skid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        skids_empty |-> !any_unblocking);

endmodule

// File: tb/decode_skid_stage_test.sv
`timescale 1ns/1ps
module decode_skid_stage_test;
    localparam int NT = 2, W = 2, TAG = 8, DEP = 4, TIDW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] fetch_valid = '0;
    logic [W*TIDW-1:0] fetch_tid = '0;
    logic [W*TAG-1:0] fetch_tag = '0;
    logic [NT-1:0] st_ren = '0, st_exe = '0, st_com = '0, sq = '0;
    logic [W-1:0] dec_valid;
    logic [W*TIDW-1:0] dec_tid;
    logic [W*TAG-1:0] dec_tag;
    logic [NT*3-1:0] thread_state;
    logic [NT-1:0] fetch_block, skid_overflow;
    logic any_unblocking, skids_empty;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] q0[$];
    logic [7:0] q1[$];

    always #2.5 clk = ~clk;

    decode_skid_stage #(.NT(NT), .WIDTH(W), .TAG_W(TAG), .DEPTH(DEP)) uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_tid(fetch_tid), .fetch_tag(fetch_tag),
        .stall_rename(st_ren), .stall_exec(st_exe), .stall_commit(st_com), .squash(sq),
        .dec_valid(dec_valid), .dec_tid(dec_tid), .dec_tag(dec_tag),
        .thread_state(thread_state), .fetch_block(fetch_block),
        .any_unblocking(any_unblocking), .skids_empty(skids_empty),
        .skid_overflow(skid_overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: present one instruction; push it as expected if it must arrive.
    task automatic drive(input int s, input int tid, input int tag, input bit arrives);
        fetch_valid[s] = 1'b1;
        fetch_tid[s*TIDW +: TIDW] = TIDW'(tid);
        fetch_tag[s*TAG +: TAG] = TAG'(tag);
        if (arrives) begin
            if (tid == 0) q0.push_back(TAG'(tag));
            else          q1.push_back(TAG'(tag));
        end
    endtask

    task automatic step();
        @(negedge clk);
        fetch_valid = '0;
    endtask

    function automatic int st(input int t);
        return int'(thread_state[t*3 +: 3]);
    endfunction

    // Monitor: pop the expected tag of the reported thread and compare.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int s = 0; s < W; s++) begin
                if (dec_valid[s]) begin
                    int tid;
                    logic [7:0] got;
                    tid = int'(dec_tid[s*TIDW +: TIDW]);
                    got = dec_tag[s*TAG +: TAG];
                    checks++;
                    if (tid == 0 && q0.size() > 0) begin
                        logic [7:0] w0;
                        w0 = q0.pop_front();
                        if (got != w0) begin
                            errors++;
                            $display("FAIL R2/R5 order t0: actual %0h expected %0h", got, w0);
                        end
                    end else if (tid == 1 && q1.size() > 0) begin
                        logic [7:0] w1;
                        w1 = q1.pop_front();
                        if (got != w1) begin
                            errors++;
                            $display("FAIL R2/R5 order t1: actual %0h expected %0h", got, w1);
                        end
                    end else begin
                        errors++;
                        $display("FAIL R2 unexpected output: actual tag %0h thread %0d expected none", got, tid);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, errors > checks ? errors : checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 dec_valid", int'(dec_valid), 0);
        chk("R1 state", int'(thread_state), 0);
        chk("R1 fetch_block", int'(fetch_block), 0);
        chk("R1 skids_empty", int'(skids_empty), 1);
        chk("R1 any_unblocking", int'(any_unblocking), 0);
        chk("R1 overflow", int'(skid_overflow), 0);

        // R2: mixed bundle, thread 0 placed first
        drive(0, 1, 'h10, 1); drive(1, 0, 'h11, 1); step();
        chk("R2 valid", int'(dec_valid), 3);
        chk("R2 slot0 thread", int'(dec_tid[0]), 0);
        chk("R2 state t0 running", st(0), 1);
        step();
        chk("R2 idle again", st(0), 0);

        // R4 and R5: execute stall, skid capture, drain
        st_exe[0] = 1'b1; drive(0, 0, 'h20, 1); step();
        chk("R4 flag not yet seen", st(0), 1);
        drive(0, 0, 'h21, 1); drive(1, 0, 'h22, 1); step();
        chk("R4 nothing out", int'(dec_valid), 0);
        chk("R4 blocked", st(0), 2);
        chk("R4 fetch_block", int'(fetch_block), 1);
        drive(0, 0, 'h23, 1); drive(1, 1, 'h30, 1); step();
        chk("R4 other thread flows", int'(dec_valid), 1);
        chk("R4 other thread slot0", int'(dec_tid[0]), 1);
        st_exe[0] = 1'b0; step();
        chk("R4 still held", int'(dec_valid), 0);
        drive(0, 0, 'h24, 1); step();
        chk("R5 unblocking", st(0), 3);
        chk("R8 any_unblocking", int'(any_unblocking), 1);
        chk("R8 skids_empty low", int'(skids_empty), 0);
        chk("R5 fetch_block held", int'(fetch_block), 1);
        step();
        chk("R5 running", st(0), 1);
        chk("R8 any_unblocking clear", int'(any_unblocking), 0);
        chk("R8 skids_empty", int'(skids_empty), 1);
        chk("R5 fetch_block released", int'(fetch_block), 0);

        // R4: each stall source alone blocks thread 1
        for (int src = 0; src < 3; src++) begin
            if (src == 0) st_ren[1] = 1'b1;
            if (src == 1) st_exe[1] = 1'b1;
            if (src == 2) st_com[1] = 1'b1;
            step();
            drive(0, 1, 'h40 + src, 1); step();
            chk("R4 source blocks", int'(dec_valid), 0);
            chk("R4 source state", st(1), 2);
            st_ren = '0; st_exe = '0; st_com = '0;
            step(); step();
            chk("R4 source released", st(1), 1);
        end

        // R7: thread 0 drains two, thread 1 pushed to its skid
        st_ren[0] = 1'b1; step();
        drive(0, 0, 'h50, 1); drive(1, 0, 'h51, 1); step();
        st_ren[0] = 1'b0; step();
        drive(0, 1, 'h60, 1); step();
        chk("R7 both slots", int'(dec_valid), 3);
        chk("R7 both thread 0", int'(dec_tid), 0);
        chk("R7 thread 1 unblocking", st(1), 3);
        step();
        chk("R7 thread 1 drained", st(1), 1);

        // R6: squash thread 1 while blocked with skid contents
        st_com[1] = 1'b1; step();
        drive(0, 1, 'h80, 0); drive(1, 1, 'h81, 0); step();
        sq[1] = 1'b1; st_com[1] = 1'b0;
        drive(0, 1, 'h82, 0); drive(1, 0, 'h70, 1); step();
        chk("R6 squashing", st(1), 4);
        chk("R6 skid emptied", int'(skids_empty), 1);
        chk("R6 thread 0 unaffected", int'(dec_valid), 1);
        sq[1] = 1'b0;
        drive(0, 1, 'h83, 0); step();
        chk("R6 drop in squash cycle", int'(dec_valid), 0);
        chk("R6 idle after", st(1), 0);
        drive(0, 1, 'h84, 1); step();
        chk("R6 resumes", st(1), 1);

        // R3: overflow of a depth-4 skid
        st_exe[0] = 1'b1; step();
        drive(0, 0, 'h90, 1); drive(1, 0, 'h91, 1); step();
        drive(0, 0, 'h92, 1); drive(1, 0, 'h93, 1); step();
        chk("R3 full no overflow", int'(skid_overflow), 0);
        drive(0, 0, 'h94, 0); drive(1, 0, 'h95, 0); step();
        chk("R3 overflow raised", int'(skid_overflow), 1);
        st_exe[0] = 1'b0; step(); step(); step();
        chk("R3 drained running", st(0), 1);
        chk("R3 overflow sticky", int'(skid_overflow), 1);
        step();

        chk("R6/R3 all expected delivered", q0.size() + q1.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule